// File: doc/BRIEF.md
# Bit-Serial Cyclic Code Syndrome Generator

This block takes a received word of a (7,4) cyclic code one bit per clock and divides its polynomial by the code generator g(x). The divider is a feedback shift register with n−k stages. When the last of the n bits has been taken in, the register holds the remainder, which is the syndrome. The block captures that value on a parallel output, raises a flag when it is nonzero, and then spends n−k cycles moving the syndrome out on a serial pin. The shifts that move it out pull zeros in, so the register is empty again when the next word starts. The syndrome output stays valid until a later word replaces it.

A zero syndrome means that no error was seen. It can also mean that the error pattern is itself a multiple of g(x), which this code cannot detect. A nonzero syndrome means that an error was detected. The generator is a parameter. The default is 1 + x^2 + x^3, and 1 + x + x^3 is also supported.

Top module: `syndrome_serial`

## Requirements
- R1: While reset is held and in the first cycle after it, in_ready is 1, syn_valid is 0, ser_valid is 0 and syn_par is 0.
- R2: A received word is made of N bits, each accepted on a clock edge where both in_valid and in_ready are 1. The coefficient of x^(N−1) comes first and the coefficient of x^0 comes last. The division register is all zeros when a word starts.
- R3: In the cycle after the N-th bit is accepted, syn_valid is 1 for exactly one cycle. syn_par then carries r(x) mod g(x), with bit i holding the coefficient of x^i. syn_par keeps this value until the next word completes.
- R4: syn_nz is 1 exactly when syn_par is not zero.
- R5: The drain phase starts in the cycle where syn_valid is 1 and lasts exactly N−K cycles. During those cycles ser_valid is 1 and ser_bit gives the syndrome coefficients, starting with x^(N−K−1) and ending with x^0.
- R6: During the drain phase in_ready is 0. Any value on in_valid or in_bit in those cycles has no effect on any later syndrome.
- R7: When the drain phase ends the register is cleared. in_ready returns to 1 in the next cycle and a new word can start at once.
- R8: Parameter GEN holds g_0 to g_(N−K−1), with bit i equal to g_i; g_(N−K) is always 1. With the default GEN = 3'b101 (g = 1 + x^2 + x^3), every codeword gives a zero syndrome. This includes c0..c6 = 1000101 (the message 0101).
- R9: With GEN = 3'b011 (g = 1 + x + x^3), every one of the 128 possible received words gives the correct remainder, and every codeword gives zero.
- R10: For both generators, every single-bit error added to any codeword gives a nonzero syndrome. The seven error positions give seven different syndromes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A received bit is present on in_bit |
| in_bit | input | 1 | Received bit, highest order first |
| in_ready | output | 1 | The block is in the input phase and takes bits |
| syn_valid | output | 1 | One-cycle pulse: a new syndrome is on syn_par |
| syn_par | output | N−K | Syndrome of the last completed word, held |
| syn_nz | output | 1 | The held syndrome is not zero |
| ser_valid | output | 1 | Drain phase: ser_bit carries a syndrome bit |
| ser_bit | output | 1 | Serial syndrome bit, highest order first |

## Verification
A wrong feedback tap or a wrong stage link changes the remainder. It shows on syn_par one cycle after the last input bit, and the full sweep over all 128 received words exposes it. A register that is not cleared after the drain shows up as a wrong syndrome for the next word. The bench forces that case by sending words back to back and by driving stray input during the drain. A phase counter that is off by one shows at the ports within a single word: the syndrome pulse arrives at the wrong time, or the drain runs too long or too short.

// File: rtl/syndrome_pkg.sv
package syndrome_pkg;
  typedef enum logic {PH_LOAD = 1'b0, PH_DRAIN = 1'b1} phase_t;
endpackage

// File: rtl/syn_phase_ctrl.sv
module syn_phase_ctrl
  import syndrome_pkg::*;
#(
  parameter int N = 7,
  parameter int R = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic load_en,
  output logic last_in,
  output logic drain_en,
  output logic word_start
);
  localparam int CW = $clog2(N);
  localparam logic [CW-1:0] LAST_IN  = CW'(N - 1);
  localparam logic [CW-1:0] LAST_OUT = CW'(R - 1);

  phase_t        phase;
  logic [CW-1:0] cnt;

  assign in_ready   = (phase == PH_LOAD);
  assign load_en    = in_ready && in_valid;
  assign last_in    = load_en && (cnt == LAST_IN);
  assign drain_en   = (phase == PH_DRAIN);
  assign word_start = in_ready && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_LOAD;
      cnt   <= '0;
    end else if (phase == PH_LOAD) begin
      if (load_en) begin
        if (cnt == LAST_IN) begin
          phase <= PH_DRAIN;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else begin
      if (cnt == LAST_OUT) begin
        phase <= PH_LOAD;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/syn_divider.sv
module syn_divider #(
  parameter int R = 3,
  parameter logic [R-1:0] GEN = 3'b101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic         drain_en,
  input  logic         in_bit,
  output logic [R-1:0] rem_q,
  output logic [R-1:0] rem_next
);
  logic fb;
  assign fb = rem_q[R-1];

  // one division step: multiply by x, add the new bit, reduce by g(x)
  genvar i;
  generate
    for (i = 0; i < R; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign rem_next[i] = in_bit ^ (fb & GEN[i]);
      end else begin : g_rest
        assign rem_next[i] = rem_q[i-1] ^ (fb & GEN[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load_en) begin
      rem_q <= rem_next;
    end else if (drain_en) begin
      rem_q <= {rem_q[R-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/syndrome_serial.sv
module syndrome_serial #(
  parameter int N = 7,
  parameter int K = 4,
  parameter logic [N-K-1:0] GEN = 3'b101
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_bit,
  output logic           in_ready,
  output logic           syn_valid,
  output logic [N-K-1:0] syn_par,
  output logic           syn_nz,
  output logic           ser_valid,
  output logic           ser_bit
);
  localparam int R = N - K;

  logic         load_en, last_in, drain_en, word_start;
  logic [R-1:0] rem_q, rem_next;
  logic         lfsr_zero;
  logic [R-1:0] syn_hold;
  logic         syn_pulse;

  syn_phase_ctrl #(.N(N), .R(R)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .load_en(load_en), .last_in(last_in), .drain_en(drain_en),
    .word_start(word_start)
  );

  syn_divider #(.R(R), .GEN(GEN)) u_div (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .drain_en(drain_en),
    .in_bit(in_bit), .rem_q(rem_q), .rem_next(rem_next)
  );

  assign lfsr_zero = (rem_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn_hold  <= '0;
      syn_pulse <= 1'b0;
    end else begin
      syn_pulse <= last_in;
      if (last_in) syn_hold <= rem_next;
    end
  end

  assign syn_valid = syn_pulse;
  assign syn_par   = syn_hold;
  assign syn_nz    = |syn_hold;
  assign ser_valid = drain_en;
  assign ser_bit   = rem_q[R-1];
endmodule

// File: rtl/syndrome_serial_chk.sv
module syndrome_serial_chk #(
  parameter int R = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_ready,
  input logic         syn_valid,
  input logic [R-1:0] syn_par,
  input logic         ser_valid,
  input logic         ser_bit,
  input logic         lfsr_zero,
  input logic         word_start
);
  logic [7:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (ser_valid) run <= run + 1'b1;
    else run <= '0;
  end

  // R6
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && ser_valid));

  // R3
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syn_valid |=> !syn_valid);

  // R5
  drain_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syn_valid |-> (ser_valid && ser_bit == syn_par[R-1]));

  // R5
  drain_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_valid) |-> (run == 8'(R)));

  // R5
  drain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> (run < 8'(R)));

  // R7
  cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_valid) |-> lfsr_zero);

  // R2
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |-> lfsr_zero);
endmodule

bind syndrome_serial syndrome_serial_chk #(.R(R)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .syn_valid(syn_valid),
  .syn_par(syn_par), .ser_valid(ser_valid), .ser_bit(ser_bit),
  .lfsr_zero(lfsr_zero), .word_start(word_start)
);

// File: tb/syndrome_serial_test.sv
module syndrome_serial_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  always #5 clk = ~clk;

  logic       rdy_a, sv_a, nz_a, qv_a, qb_a;
  logic [2:0] sp_a;
  logic       rdy_b, sv_b, nz_b, qv_b, qb_b;
  logic [2:0] sp_b;

  syndrome_serial #(.N(7), .K(4), .GEN(3'b101)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(rdy_a), .syn_valid(sv_a), .syn_par(sp_a), .syn_nz(nz_a),
    .ser_valid(qv_a), .ser_bit(qb_a)
  );
  syndrome_serial #(.N(7), .K(4), .GEN(3'b011)) uut_b (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(rdy_b), .syn_valid(sv_b), .syn_par(sp_b), .syn_nz(nz_b),
    .ser_valid(qv_b), .ser_bit(qb_b)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // remainder by long division on the full generator (x^3 term included)
  function automatic logic [2:0] pmod(input logic [6:0] w, input logic [3:0] g);
    logic [6:0] v = w;
    for (int d = 6; d >= 3; d--)
      if (v[d]) v = v ^ (7'(g) << (d - 3));
    return v[2:0];
  endfunction

  function automatic logic [6:0] encode(input logic [3:0] m, input logic [3:0] g);
    logic [6:0] sh = {m, 3'b000};
    return sh | {4'b0, pmod(sh, g)};
  endfunction

  localparam logic [3:0] GA = 4'b1101; // 1 + x^2 + x^3
  localparam logic [3:0] GB = 4'b1011; // 1 + x + x^3

  // sends one word (bit 6 first); stray input is driven during the drain
  task automatic run_word(input logic [6:0] w, output logic [2:0] ra, output logic [2:0] rb);
    logic [2:0] ea = pmod(w, GA);
    logic [2:0] eb = pmod(w, GB);
    for (int i = 6; i >= 0; i--) begin
      @(negedge clk);
      chk("R2 ready during load", {7'b0, rdy_a}, 8'd1);
      in_valid = 1'b1;
      in_bit = w[i];
    end
    @(negedge clk);
    in_valid = 1'b1; // R6: ignored during drain
    in_bit = 1'b1;
    chk("R3 syn_valid a", {7'b0, sv_a}, 8'd1);
    chk("R3 syn_valid b", {7'b0, sv_b}, 8'd1);
    chk("R8 syndrome a", {5'b0, sp_a}, {5'b0, ea});
    chk("R9 syndrome b", {5'b0, sp_b}, {5'b0, eb});
    chk("R4 nz a", {7'b0, nz_a}, {7'b0, |ea});
    chk("R4 nz b", {7'b0, nz_b}, {7'b0, |eb});
    chk("R6 ready low", {7'b0, rdy_a}, 8'd0);
    for (int j = 0; j < 3; j++) begin
      if (j > 0) @(negedge clk);
      in_bit = j[0];
      chk("R5 ser_valid", {6'b0, qv_a, qv_b}, 8'd3);
      chk("R5 ser_bit a", {7'b0, qb_a}, {7'b0, ea[2-j]});
      chk("R5 ser_bit b", {7'b0, qb_b}, {7'b0, eb[2-j]});
      if (j > 0) chk("R3 pulse single", {6'b0, sv_a, sv_b}, 8'd0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 ready back", {6'b0, rdy_a, rdy_b}, 8'd3);
    chk("R5 drain ended", {6'b0, qv_a, qv_b}, 8'd0);
    chk("R3 held a", {5'b0, sp_a}, {5'b0, ea});
    ra = sp_a;
    rb = sp_b;
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [2:0] ra, rb;
    logic [2:0] sa [7];
    logic [2:0] sb [7];
    logic [6:0] cw;
    repeat (2) @(negedge clk);
    chk("R1 reset ready", {6'b0, rdy_a, rdy_b}, 8'd3);
    chk("R1 reset valids", {4'b0, sv_a, sv_b, qv_a, qv_b}, 8'd0);
    chk("R1 reset syn", {5'b0, sp_a}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {5'b0, rdy_a, sv_a, qv_a}, 8'd4);

    // R8: codeword 1000101 (c0 first) -> w = 7'b1010001
    run_word(7'b1010001, ra, rb);
    chk("R8 known codeword zero", {5'b0, ra}, 8'd0);

    // R9 R8: all received words, back to back
    for (int w = 0; w < 128; w++) run_word(7'(w), ra, rb);

    // R10: every codeword, every single-bit error
    for (int m = 0; m < 16; m++) begin
      cw = encode(4'(m), GA);
      run_word(cw, ra, rb);
      chk("R8 codeword zero", {5'b0, ra}, 8'd0);
      cw = encode(4'(m), GB);
      run_word(cw, ra, rb);
      chk("R9 codeword zero", {5'b0, rb}, 8'd0);
      for (int p = 0; p < 7; p++) begin
        run_word(encode(4'(m), GA) ^ (7'd1 << p), ra, rb);
        sa[p] = ra;
        run_word(encode(4'(m), GB) ^ (7'd1 << p), ra, rb);
        sb[p] = rb;
        chk("R10 nonzero", {6'b0, |sa[p], |sb[p]}, 8'd3);
      end
      for (int p = 0; p < 7; p++)
        for (int q = p + 1; q < 7; q++)
          chk("R10 distinct", {6'b0, sa[p] == sa[q], sb[p] == sb[q]}, 8'd0);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule